// File: doc/BRIEF.md
# Edge-Triggered Interrupt Flag Controller

This block collects up to sixteen asynchronous interrupt request lines, brings each one into the local clock domain and records every rising transition as a sticky pending flag. A second register holds one disable bit per source. A single registered interrupt line goes to the host processor. It is raised while at least one source in a fixed output group is both pending and not disabled. The group is a build-time parameter and defaults to sources 8, 9 and 10.

Software reaches both registers over a plain 16-bit register port with a byte address, a write strobe, write data and read data. Read data follows the address with one cycle of latency. Masking and acknowledging are separate operations. To mask a source, software reads the disable register, modifies it and writes it back. To acknowledge a source, software writes the pending register with a zero in that source's bit position and ones everywhere else.

Top module: `irqc_top`

## Requirements
- R1: Reset is synchronous and active high. After reset the pending register reads 0x0000, the disable register reads 0xFFFF (all sources disabled), `irq_out` is 0 and `bus_rdata` is 0.
- R2: A low-to-high transition on `irq_src[i]` sets pending bit i. The first clock edge that samples the input high is edge n, and the flag is set from edge n+2. A steady high level or a falling transition sets nothing.
- R3: A pending bit stays set until software clears it, whatever the input does afterwards.
- R4: A write to byte address 0x2 clears each pending bit whose write-data bit is 0. Bits written as 1 keep their value, so writing 0xFFFF clears nothing.
- R5: If a rising transition is latched at the same clock edge as a write that clears that bit, the bit ends up set. Other bits cleared by the same write still clear.
- R6: A write to byte address 0xA loads the disable register with the write data. A bit value of 1 disables the source and 0 enables it. The written value reads back unchanged.
- R7: At each clock edge `irq_out` is loaded with the OR over all sources of (pending AND NOT disabled AND group bit), using the register values before that edge. The default group is 0x0700. Sources outside the group never raise `irq_out`.
- R8: `bus_rdata` at clock edge n holds the register selected by `bus_addr` at that edge: pending at 0x2, disable at 0xA. The value is taken before any write at that same edge takes effect.
- R9: Every other address reads 0x0000, and a write to such an address changes neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | 16 | Asynchronous interrupt request lines, one per source |
| bus_addr | input | 4 | Byte address of the register access |
| bus_we | input | 1 | Write strobe for the current address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, one cycle after the address |
| irq_out | output | 1 | Registered combined interrupt to the host |

## Verification
A change on a request line sampled at clock edge n reaches the pending register at edge n+2 and `irq_out` at edge n+3. A read or a disable-register write takes effect at the next edge, and `irq_out` follows a register change one edge later. The bench drives every input at the falling edge. A bench model advances exactly once per rising edge: it records the input samples, computes the read data and output due at that edge from the values held before the edge, and then applies the write. The design outputs are compared against the model at the following falling edge. The directed cases count their steps against these same delays, including the case where an edge and a clear of the same bit land at the same edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned DATA_W = 16;
    localparam int unsigned ADDR_W = 4;

    // Byte offsets software relies on
    localparam logic [ADDR_W-1:0] PEND_OFS = 4'h2;
    localparam logic [ADDR_W-1:0] MASK_OFS = 4'hA;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_PEND = 2'd1,
        SEL_MASK = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic              wr;
        reg_sel_e          sel;
        logic [DATA_W-1:0] data;
    } bus_req_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        if (a == PEND_OFS) begin
            return SEL_PEND;
        end
        if (a == MASK_OFS) begin
            return SEL_MASK;
        end
        return SEL_NONE;
    endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[g] <= '0;
                end else begin
                    chain[g] <= din;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[g] <= '0;
                end else begin
                    chain[g] <= chain[g-1];
                end
            end
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/irqc_edge.sv
module irqc_edge #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise
);

    logic [WIDTH-1:0] level_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_prev <= '0;
        end else begin
            level_prev <= level;
        end
    end

    assign rise = level & ~level_prev;

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  bus_req_t           req,
    input  logic [NUM_SRC-1:0] rise,
    output logic [NUM_SRC-1:0] pend_q,
    output logic [NUM_SRC-1:0] mask_q,
    output logic [DATA_W-1:0]  rdata
);

    logic [NUM_SRC-1:0] pend_d;
    logic [NUM_SRC-1:0] mask_d;
    logic [NUM_SRC-1:0] wr_bits;
    logic [DATA_W-1:0]  rdata_d;

    assign wr_bits = req.data[NUM_SRC-1:0];

    always_comb begin
        pend_d = pend_q;
        mask_d = mask_q;
        if (req.wr) begin
            unique case (req.sel)
                SEL_PEND: pend_d = pend_q & wr_bits;
                SEL_MASK: mask_d = wr_bits;
                default:  ;
            endcase
        end
        // A fresh edge overrides a same-cycle clear
        pend_d = pend_d | rise;
    end

    always_comb begin
        rdata_d = '0;
        unique case (req.sel)
            SEL_PEND: rdata_d[NUM_SRC-1:0] = pend_q;
            SEL_MASK: rdata_d[NUM_SRC-1:0] = mask_q;
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            mask_q <= '1;
            rdata  <= '0;
        end else begin
            pend_q <= pend_d;
            mask_q <= mask_d;
            rdata  <= rdata_d;
        end
    end

endmodule

// File: rtl/irqc_combine.sv
module irqc_combine #(
    parameter int unsigned         NUM_SRC    = 16,
    parameter logic [NUM_SRC-1:0]  GROUP_MASK = 16'h0700
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] mask,
    output logic               irq_out
);

    logic [NUM_SRC-1:0] live;

    assign live = pend & ~mask & GROUP_MASK;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_out <= 1'b0;
        end else begin
            irq_out <= |live;
        end
    end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int unsigned        NUM_SRC     = 16,
    parameter int unsigned        SYNC_STAGES = 2,
    parameter logic [NUM_SRC-1:0] GROUP_MASK  = 16'h0700
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_src,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_out
);

    logic [NUM_SRC-1:0] src_sync;
    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] mask_q;
    bus_req_t           req;

    always_comb begin
        req.wr   = bus_we;
        req.sel  = decode_addr(bus_addr);
        req.data = bus_wdata;
    end

    irqc_sync #(
        .WIDTH (NUM_SRC),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .din (irq_src),
        .dout(src_sync)
    );

    irqc_edge #(
        .WIDTH(NUM_SRC)
    ) u_edge (
        .clk  (clk),
        .rst  (rst),
        .level(src_sync),
        .rise (rise)
    );

    irqc_regs #(
        .NUM_SRC(NUM_SRC)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .rise  (rise),
        .pend_q(pend_q),
        .mask_q(mask_q),
        .rdata (bus_rdata)
    );

    irqc_combine #(
        .NUM_SRC   (NUM_SRC),
        .GROUP_MASK(GROUP_MASK)
    ) u_combine (
        .clk    (clk),
        .rst    (rst),
        .pend   (pend_q),
        .mask   (mask_q),
        .irq_out(irq_out)
    );

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
    import irqc_pkg::*;
#(
    parameter int unsigned        NUM_SRC    = 16,
    parameter logic [NUM_SRC-1:0] GROUP_MASK = 16'h0700
) (
    input logic               clk,
    input logic               rst,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_we,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic               irq_out,
    input logic [NUM_SRC-1:0] pend_q,
    input logic [NUM_SRC-1:0] mask_q,
    input logic [NUM_SRC-1:0] rise
);

    logic hit_pend;
    logic hit_mask;
    logic unmapped;
    logic live_any;

    assign hit_pend = (bus_addr == PEND_OFS);
    assign hit_mask = (bus_addr == MASK_OFS);
    assign unmapped = !hit_pend && !hit_mask;
    assign live_any = |(pend_q & ~mask_q & GROUP_MASK);

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pend_q == '0 && mask_q == '1 && !irq_out && bus_rdata == '0)); // R1

    AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (rst)
        (rise != '0) |=> ((pend_q & $past(rise)) == $past(rise))); // R2

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && hit_pend) |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R3

    AST_ACK_ZERO_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (bus_we && hit_pend) |=> ((pend_q & ~($past(bus_wdata[NUM_SRC-1:0]) | $past(rise))) == '0)); // R4

    AST_ACK_ONES_KEEP: assert property (@(posedge clk) disable iff (rst)
        (bus_we && hit_pend) |=> ((pend_q & $past(pend_q) & $past(bus_wdata[NUM_SRC-1:0]))
                                   == ($past(pend_q) & $past(bus_wdata[NUM_SRC-1:0])))); // R4

    AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (bus_we && hit_pend && rise != '0) |=> ((pend_q & $past(rise)) == $past(rise))); // R5

    AST_MASK_STORE: assert property (@(posedge clk) disable iff (rst)
        (bus_we && hit_mask) |=> (mask_q == $past(bus_wdata[NUM_SRC-1:0]))); // R6

    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (rst)
        live_any |=> irq_out); // R7

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        !live_any |=> !irq_out); // R7

    AST_READ_MASK: assert property (@(posedge clk) disable iff (rst)
        hit_mask |=> (bus_rdata[NUM_SRC-1:0] == $past(mask_q))); // R8

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        unmapped |=> (bus_rdata == '0)); // R9

    AST_UNMAPPED_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_we && unmapped) |=> (mask_q == $past(mask_q))); // R9

endmodule

bind irqc_top irqc_chk #(
    .NUM_SRC   (NUM_SRC),
    .GROUP_MASK(GROUP_MASK)
) u_irqc_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq_out  (irq_out),
    .pend_q   (pend_q),
    .mask_q   (mask_q),
    .rise     (rise)
);

// File: tb/test_irqc_top.sv
module test_irqc_top;

    localparam logic [15:0] GROUP = 16'h0700;
    localparam logic [3:0]  A_PEND = 4'h2;
    localparam logic [3:0]  A_MASK = 4'hA;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] irq_src = '0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_out;

    int unsigned n_chk = 0;
    int unsigned n_fail = 0;
    int unsigned cycles = 0;

    // bench model state
    logic [15:0] m_pend, m_mask;
    logic [15:0] h0, h1, h2;
    logic [15:0] exp_rd;
    logic        exp_irq;

    always #2.5 clk = ~clk;

    irqc_top i_irqc_top (
        .clk      (clk),
        .rst      (rst),
        .irq_src  (irq_src),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq_out  (irq_out)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] next_pend(input logic [15:0] pend, input logic wr_ack,
                                              input logic [15:0] wd, input logic [15:0] rise);
        logic [15:0] p;
        p = wr_ack ? (pend & wd) : pend;
        return p | rise;
    endfunction

    function automatic logic [15:0] read_of(input logic [3:0] a, input logic [15:0] pend,
                                            input logic [15:0] mask);
        if (a == A_PEND) return pend;
        if (a == A_MASK) return mask;
        return 16'h0000;
    endfunction

    // Drive at falling edge, advance model at rising edge, compare at next falling edge
    task automatic step(input logic [15:0] src, input logic [3:0] a, input logic we,
                        input logic [15:0] wd);
        logic [15:0] rise;
        irq_src   = src;
        bus_addr  = a;
        bus_we    = we;
        bus_wdata = wd;
        @(posedge clk);
        exp_rd  = read_of(a, m_pend, m_mask);
        exp_irq = |(m_pend & ~m_mask & GROUP);
        rise    = h1 & ~h2;
        h2 = h1;
        h1 = h0;
        h0 = src;
        m_pend = next_pend(m_pend, we && a == A_PEND, wd, rise);
        if (we && a == A_MASK) m_mask = wd;
        @(negedge clk);
        if (a == A_PEND || a == A_MASK) check("R8 read data", bus_rdata, exp_rd);
        else check("R9 unmapped read", bus_rdata, exp_rd);
        check("R7 irq_out", {15'd0, irq_out}, {15'd0, exp_irq});
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000) begin
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    initial begin : main
        logic [15:0] cur;
        void'($urandom(32'h5eed_1a2b));
        m_pend = '0; m_mask = '1; h0 = '0; h1 = '0; h2 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 irq_out after reset", {15'd0, irq_out}, 16'h0000);
        check("R1 rdata after reset", bus_rdata, 16'h0000);
        step(16'h0000, A_MASK, 1'b0, 16'h0000);
        check("R1 mask reset", bus_rdata, 16'hFFFF);
        step(16'h0000, A_PEND, 1'b0, 16'h0000);
        check("R1 pend reset", bus_rdata, 16'h0000);

        // enable sources 8..10
        step(16'h0000, A_MASK, 1'b1, 16'hF8FF);

        // R2 rising edges on sources 0 and 9
        repeat (4) step(16'h0201, A_PEND, 1'b0, 16'h0000);
        check("R2 flags set", bus_rdata, 16'h0201);
        check("R7 irq from source 9", {15'd0, irq_out}, 16'h0001);

        // R3 falling inputs leave flags set
        repeat (3) step(16'h0000, A_PEND, 1'b0, 16'h0000);
        check("R3 flags sticky", bus_rdata, 16'h0201);

        // R4 all-ones write clears nothing
        step(16'h0000, A_PEND, 1'b1, 16'hFFFF);
        step(16'h0000, A_PEND, 1'b0, 16'h0000);
        check("R4 ones keep", bus_rdata, 16'h0201);

        // R4 zero in bit 9 clears it
        step(16'h0000, A_PEND, 1'b1, 16'hFDFF);
        step(16'h0000, A_PEND, 1'b0, 16'h0000);
        check("R4 zero clears", bus_rdata, 16'h0001);
        check("R7 irq drops after ack", {15'd0, irq_out}, 16'h0000);

        // R5 edge on source 3 latched at the same edge as a clear of bits 0 and 3
        step(16'h0008, A_PEND, 1'b0, 16'h0000);
        step(16'h0008, A_PEND, 1'b0, 16'h0000);
        step(16'h0008, A_PEND, 1'b1, 16'hFFF6);
        step(16'h0008, A_PEND, 1'b0, 16'h0000);
        check("R5 edge wins over clear", bus_rdata, 16'h0008);

        // R7 source outside the group with everything enabled
        step(16'h0008, A_MASK, 1'b1, 16'h0000);
        step(16'h0008, A_MASK, 1'b0, 16'h0000);
        check("R6 mask readback", bus_rdata, 16'h0000);
        check("R7 out-of-group quiet", {15'd0, irq_out}, 16'h0000);

        // R7 source 10 raises, then disabling it drops
        repeat (4) step(16'h0408, A_PEND, 1'b0, 16'h0000);
        check("R7 source 10 raises", {15'd0, irq_out}, 16'h0001);
        step(16'h0408, A_MASK, 1'b1, 16'h0400);
        step(16'h0408, A_PEND, 1'b0, 16'h0000);
        check("R7 disable drops irq", {15'd0, irq_out}, 16'h0000);
        step(16'h0408, A_MASK, 1'b0, 16'h0000);
        check("R6 mask readback 0400", bus_rdata, 16'h0400);

        // R9 unmapped writes ignored, reads zero
        step(16'h0408, 4'h4, 1'b1, 16'h0000);
        step(16'h0408, 4'h3, 1'b1, 16'h0000);
        check("R9 unmapped reads zero", bus_rdata, 16'h0000);
        step(16'h0408, A_PEND, 1'b0, 16'h0000);
        check("R9 pend untouched", bus_rdata, 16'h0408);
        step(16'h0408, A_MASK, 1'b0, 16'h0000);
        check("R9 mask untouched", bus_rdata, 16'h0400);

        // Constrained random phase checked against the model
        cur = 16'h0408;
        for (int i = 0; i < 3000; i++) begin
            logic [3:0]  a;
            logic        we;
            logic [15:0] wd;
            int unsigned pick;
            cur  = cur ^ (16'($urandom) & 16'($urandom) & 16'($urandom));
            pick = $urandom % 8;
            if (pick < 3) a = A_PEND;
            else if (pick < 6) a = A_MASK;
            else a = 4'($urandom);
            we = (($urandom % 4) == 0);
            if (a == A_PEND) wd = ~(16'($urandom) & 16'($urandom));
            else wd = 16'($urandom);
            step(cur, a, we, wd);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule